// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block is the device-side write path of a synchronous DRAM model. A WRITE command names a bank, a starting column and an auto-precharge flag. The data beat that arrives with the command is stored on that same clock edge. Each later edge stores one more beat at the next column, until the burst ends. A burst ends when its programmed length is reached or when a newer WRITE takes over. The beats land in a small behavioural storage array, one array per bank. A read-only peek port lets the surrounding model or a bench inspect any stored word.

Fixed bursts of 1, 2, 4 or 8 beats step through the columns in order and wrap inside their aligned block. Continuous full-page bursts step across the whole row, wrap from the last column to column 0, and run until another WRITE arrives. A per-beat mask can suppress the store of a beat without disturbing the column sequence. When a burst with auto-precharge runs to its natural end, the block raises a one-cycle precharge request for that bank.

Top module: `sdr_wr_burst_seq`

## Requirements
- R1: On an edge where `cmd_wr` is high, the beat on `din` is stored at bank `cmd_bank`, column `cmd_col`, and `beat_vld`/`beat_bank`/`beat_col` show that address in the same cycle.
- R2: In a fixed burst, each following edge stores one beat in the same bank. The column advances by one and wraps inside the block aligned to the burst length, so the upper column bits stay fixed. `cfg_bl` encoding: 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 to 7 = 8 beats. The length is taken when the command is accepted.
- R3: Once a fixed burst has delivered its last beat and no new WRITE has come, `beat_vld` stays low and data on `din` is not stored.
- R4: With `cfg_full_page` high at the command, the burst advances one column per edge with no end of its own. It wraps from the highest column to column 0 and stops only when a new WRITE arrives.
- R5: A WRITE accepted while a burst is running ends that burst at once. The beat presented with the new command goes to the new command's address.
- R6: A beat whose `dm` is high is not stored. The stored word keeps its old value, and the column still advances for the next beat.
- R7: When a burst with `cmd_ap` set delivers its last beat, `pre_req` is high for the following cycle with `pre_bank` equal to that burst's bank. A burst cut short by a new WRITE, or a burst without the flag, raises no request.
- R8: WRITE commands may come on consecutive cycles to the same bank or to different banks. Each one is stored without a stall.
- R9: While reset is held and just after it, `beat_vld` and `pre_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all storage on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | WRITE command strobe for this cycle |
| cmd_bank | input | BANK_W | Bank of the WRITE |
| cmd_col | input | COL_W | Starting column of the WRITE |
| cmd_ap | input | 1 | Auto-precharge flag of the WRITE |
| cfg_bl | input | 3 | Fixed burst length code, sampled with the command |
| cfg_full_page | input | 1 | Continuous full-page mode, sampled with the command |
| din | input | DATA_W | Data-in beat |
| dm | input | 1 | Mask for the current beat; high blocks the store |
| peek_bank | input | BANK_W | Bank of the inspection read |
| peek_col | input | COL_W | Column of the inspection read |
| peek_data | output | DATA_W | Stored word at the inspected address |
| beat_vld | output | 1 | A data beat is taken this cycle |
| beat_bank | output | BANK_W | Bank of the current beat |
| beat_col | output | COL_W | Column of the current beat |
| pre_req | output | 1 | One-cycle precharge request after a completed auto-precharge burst |
| pre_bank | output | BANK_W | Bank for the precharge request |

## Verification
A wrong beat counter or a stale latched length shows up in the same cycle. `beat_vld` stays high one beat too long or drops one too early, and a stray store appears in the array, which a later peek reveals. A bad column step shows on `beat_col` on the very next edge after the command. It also leaves words at the wrong column, which the final sweep of every bank and column catches. A precharge flag that is not cleared on truncation shows as a `pre_req` pulse one cycle after the interrupted burst's last completed beat.

// File: rtl/sdr_wb_pkg.sv
package sdr_wb_pkg;

   // widest fixed burst is 2**BL_LOG2_MAX beats
   localparam int BL_LOG2_MAX = 3;
   localparam int BL_CODE_W   = 3;

   typedef logic [BL_LOG2_MAX-1:0] bl_mask_t;

   // wrap mask for a burst length code: length minus one
   function automatic bl_mask_t bl_to_mask(input logic [BL_CODE_W-1:0] code);
      bl_mask_t m;
      case (code)
         3'd0:    m = 3'b000;
         3'd1:    m = 3'b001;
         3'd2:    m = 3'b011;
         default: m = 3'b111;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/sdr_wb_colgen.sv
module sdr_wb_colgen
   import sdr_wb_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [COL_W-1:0] cur_col,
   input  bl_mask_t         cur_mask,
   input  logic             cur_fp,
   output logic [COL_W-1:0] nxt_col
);

   logic [COL_W-1:0] inc_col;

   assign inc_col = cur_col + 1'b1;

   // low bits take the increment inside the burst block; upper bits only
   // move in full-page mode, where the carry wraps the whole row
   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      if (i < BL_LOG2_MAX) begin : g_low
         assign nxt_col[i] = (cur_fp | cur_mask[i]) ? inc_col[i] : cur_col[i];
      end else begin : g_high
         assign nxt_col[i] = cur_fp ? inc_col[i] : cur_col[i];
      end
   end

endmodule

// File: rtl/sdr_wb_ctrl.sv
module sdr_wb_ctrl
   import sdr_wb_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter int BANK_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_wr,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic [COL_W-1:0]     cmd_col,
   input  logic                 cmd_ap,
   input  logic [BL_CODE_W-1:0] cfg_bl,
   input  logic                 cfg_full_page,
   input  logic [COL_W-1:0]     nxt_col,
   output logic                 beat_vld,
   output logic [BANK_W-1:0]    beat_bank,
   output logic [COL_W-1:0]     beat_col,
   output bl_mask_t             cur_mask,
   output logic                 cur_fp,
   output bl_mask_t             mask_q,
   output logic                 fp_q,
   output logic                 act_q,
   output logic                 pre_req,
   output logic [BANK_W-1:0]    pre_bank
);

   logic [BANK_W-1:0]      bank_q;
   logic [COL_W-1:0]       col_q;
   logic [BL_LOG2_MAX-1:0] idx_q;
   logic                   ap_q;

   logic [BL_LOG2_MAX-1:0] cur_idx;
   logic                   cur_ap;
   logic                   last_beat;

   // a new command always overrides the running burst
   always_comb begin
      if (cmd_wr) begin
         beat_vld  = 1'b1;
         beat_bank = cmd_bank;
         beat_col  = cmd_col;
         cur_mask  = bl_to_mask(cfg_bl);
         cur_fp    = cfg_full_page;
         cur_ap    = cmd_ap;
         cur_idx   = '0;
      end else begin
         beat_vld  = act_q;
         beat_bank = bank_q;
         beat_col  = col_q;
         cur_mask  = mask_q;
         cur_fp    = fp_q;
         cur_ap    = ap_q;
         cur_idx   = idx_q;
      end
   end

   assign last_beat = beat_vld && !cur_fp && (cur_idx == cur_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         bank_q   <= '0;
         col_q    <= '0;
         idx_q    <= '0;
         mask_q   <= '0;
         fp_q     <= 1'b0;
         ap_q     <= 1'b0;
         pre_req  <= 1'b0;
         pre_bank <= '0;
      end else begin
         pre_req <= last_beat && cur_ap;
         if (last_beat && cur_ap) begin
            pre_bank <= beat_bank;
         end
         if (beat_vld) begin
            act_q  <= !last_beat;
            bank_q <= beat_bank;
            col_q  <= nxt_col;
            idx_q  <= cur_idx + 1'b1;
            mask_q <= cur_mask;
            fp_q   <= cur_fp;
            ap_q   <= cur_ap;
         end
      end
   end

endmodule

// File: rtl/sdr_wb_array.sv
module sdr_wb_array #(
   parameter int NUM_BANKS = 4,
   parameter int COL_W     = 8,
   parameter int DATA_W    = 16,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int NUM_COLS = 1 << COL_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [BANK_W-1:0] wbank,
   input  logic [COL_W-1:0]  wcol,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BANK_W-1:0] rbank,
   input  logic [COL_W-1:0]  rcol,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] bank_rd [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [DATA_W-1:0] cells [NUM_COLS];

      always_ff @(posedge clk) begin
         if (we && (wbank == BANK_W'(b))) begin
            cells[wcol] <= wdata;
         end
      end

      assign bank_rd[b] = cells[rcol];
   end

   always_comb begin
      rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rbank == BANK_W'(b)) rdata = bank_rd[b];
      end
   end

endmodule

// File: rtl/sdr_wr_burst_seq.sv
module sdr_wr_burst_seq
   import sdr_wb_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int COL_W     = 8,
   parameter int DATA_W    = 16,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_wr,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic [COL_W-1:0]     cmd_col,
   input  logic                 cmd_ap,
   input  logic [BL_CODE_W-1:0] cfg_bl,
   input  logic                 cfg_full_page,
   input  logic [DATA_W-1:0]    din,
   input  logic                 dm,
   input  logic [BANK_W-1:0]    peek_bank,
   input  logic [COL_W-1:0]     peek_col,
   output logic [DATA_W-1:0]    peek_data,
   output logic                 beat_vld,
   output logic [BANK_W-1:0]    beat_bank,
   output logic [COL_W-1:0]     beat_col,
   output logic                 pre_req,
   output logic [BANK_W-1:0]    pre_bank
);

   // elaboration-time parameter checks
   if (COL_W < BL_LOG2_MAX) begin : g_bad_col
      $error("COL_W must cover the longest fixed burst");
   end
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("NUM_BANKS must be at least one");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least one");
   end

   bl_mask_t         cur_mask;
   bl_mask_t         mask_q;
   logic             cur_fp;
   logic             fp_q;
   logic             act_q;
   logic [COL_W-1:0] nxt_col;
   logic             mem_we;

   sdr_wb_ctrl #(
      .COL_W  (COL_W),
      .BANK_W (BANK_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_wr        (cmd_wr),
      .cmd_bank      (cmd_bank),
      .cmd_col       (cmd_col),
      .cmd_ap        (cmd_ap),
      .cfg_bl        (cfg_bl),
      .cfg_full_page (cfg_full_page),
      .nxt_col       (nxt_col),
      .beat_vld      (beat_vld),
      .beat_bank     (beat_bank),
      .beat_col      (beat_col),
      .cur_mask      (cur_mask),
      .cur_fp        (cur_fp),
      .mask_q        (mask_q),
      .fp_q          (fp_q),
      .act_q         (act_q),
      .pre_req       (pre_req),
      .pre_bank      (pre_bank)
   );

   sdr_wb_colgen #(
      .COL_W (COL_W)
   ) u_colgen (
      .cur_col  (beat_col),
      .cur_mask (cur_mask),
      .cur_fp   (cur_fp),
      .nxt_col  (nxt_col)
   );

   assign mem_we = beat_vld && !dm;

   sdr_wb_array #(
      .NUM_BANKS (NUM_BANKS),
      .COL_W     (COL_W),
      .DATA_W    (DATA_W)
   ) u_array (
      .clk   (clk),
      .we    (mem_we),
      .wbank (beat_bank),
      .wcol  (beat_col),
      .wdata (din),
      .rbank (peek_bank),
      .rcol  (peek_col),
      .rdata (peek_data)
   );

endmodule

// File: rtl/sdr_wr_burst_seq_chk.sv
module sdr_wr_burst_seq_chk
   import sdr_wb_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter int BANK_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_wr,
   input logic [BANK_W-1:0] cmd_bank,
   input logic [COL_W-1:0]  cmd_col,
   input logic              beat_vld,
   input logic [BANK_W-1:0] beat_bank,
   input logic [COL_W-1:0]  beat_col,
   input logic              pre_req,
   input logic [BANK_W-1:0] pre_bank,
   input bl_mask_t          mask_q,
   input logic              fp_q
);

   logic [COL_W-1:0] blk_mask;
   assign blk_mask = ~COL_W'(mask_q);

   AST_CMD_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> (beat_vld && beat_bank == cmd_bank && beat_col == cmd_col)); // R1

   AST_CONT_SAME_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && !cmd_wr) |-> ($past(beat_vld) && beat_bank == $past(beat_bank))); // R2

   AST_FIXED_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && !cmd_wr && !fp_q) |-> ((beat_col & blk_mask) == ($past(beat_col) & blk_mask))); // R2

   AST_FULL_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && !cmd_wr && fp_q) |-> (beat_col == COL_W'($past(beat_col) + 1'b1))); // R4

   AST_PRE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      pre_req |-> ($past(beat_vld) && pre_bank == $past(beat_bank))); // R7

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!pre_req && !(beat_vld && !cmd_wr))); // R9

endmodule

bind sdr_wr_burst_seq sdr_wr_burst_seq_chk #(
   .COL_W  (COL_W),
   .BANK_W (BANK_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wr    (cmd_wr),
   .cmd_bank  (cmd_bank),
   .cmd_col   (cmd_col),
   .beat_vld  (beat_vld),
   .beat_bank (beat_bank),
   .beat_col  (beat_col),
   .pre_req   (pre_req),
   .pre_bank  (pre_bank),
   .mask_q    (mask_q),
   .fp_q      (fp_q)
);

// File: tb/sdr_wr_burst_seq_tb.sv
module sdr_wr_burst_seq_tb;

   localparam int NB   = 4;
   localparam int CW   = 8;
   localparam int DW   = 16;
   localparam int BW   = 2;
   localparam int NCOL = 1 << CW;

   typedef struct {
      logic          vld;
      logic [BW-1:0] bank;
      logic [CW-1:0] col;
      logic          pre;
      logic [BW-1:0] pbank;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_wr = 1'b0;
   logic [BW-1:0] cmd_bank = '0;
   logic [CW-1:0] cmd_col = '0;
   logic          cmd_ap = 1'b0;
   logic [2:0]    cfg_bl = '0;
   logic          cfg_full_page = 1'b0;
   logic [DW-1:0] din = '0;
   logic          dm = 1'b0;
   logic [BW-1:0] peek_bank = '0;
   logic [CW-1:0] peek_col = '0;
   logic [DW-1:0] peek_data;
   logic          beat_vld;
   logic [BW-1:0] beat_bank;
   logic [CW-1:0] beat_col;
   logic          pre_req;
   logic [BW-1:0] pre_bank;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   exp_t exp_q[$];
   logic [DW-1:0] shadow [NB][NCOL];

   // bench model state
   logic          m_act = 1'b0;
   logic [BW-1:0] m_bank;
   logic [CW-1:0] m_col;
   int            m_idx;
   int            m_len;
   logic          m_fp;
   logic          m_ap;
   logic          m_pend = 1'b0;
   logic [BW-1:0] m_pbank;

   always #2.5 clk = ~clk;

   sdr_wr_burst_seq #(.NUM_BANKS(NB), .COL_W(CW), .DATA_W(DW)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_wr        (cmd_wr),
      .cmd_bank      (cmd_bank),
      .cmd_col       (cmd_col),
      .cmd_ap        (cmd_ap),
      .cfg_bl        (cfg_bl),
      .cfg_full_page (cfg_full_page),
      .din           (din),
      .dm            (dm),
      .peek_bank     (peek_bank),
      .peek_col      (peek_col),
      .peek_data     (peek_data),
      .beat_vld      (beat_vld),
      .beat_bank     (beat_bank),
      .beat_col      (beat_col),
      .pre_req       (pre_req),
      .pre_bank      (pre_bank)
   );

   function automatic int code_len(input logic [2:0] code);
      case (code)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 4;
         default: return 8;
      endcase
   endfunction

   function automatic logic [DW-1:0] pat(input int b, input int c, input int salt);
      return DW'((b * 4099 + c * 37 + salt * 911) ^ 16'h5A3C);
   endfunction

   // driver: one clock cycle of stimulus plus the expected outcome
   task automatic step(input bit c, input int b, input int col, input bit ap,
                       input int blc, input bit fp, input logic [DW-1:0] d,
                       input bit mask, input string tag);
      exp_t e;
      int   len;
      @(posedge clk);
      #1;
      cmd_wr = c; cmd_bank = BW'(b); cmd_col = CW'(col); cmd_ap = ap;
      cfg_bl = 3'(blc); cfg_full_page = fp; din = d; dm = mask;
      e.pre = m_pend; e.pbank = m_pbank; e.tag = tag;
      m_pend = 1'b0;
      if (c) begin
         m_bank = BW'(b); m_col = CW'(col); m_idx = 0;
         m_len = code_len(3'(blc)); m_fp = fp; m_ap = ap; m_act = 1'b1;
      end
      e.vld = m_act; e.bank = m_bank; e.col = m_col;
      if (m_act) begin
         len = m_len;
         if (!mask) shadow[m_bank][m_col] = d;
         if (!m_fp && m_idx == len - 1) begin
            m_act = 1'b0;
            if (m_ap) begin
               m_pend = 1'b1; m_pbank = m_bank;
            end
         end else begin
            if (m_fp) m_col = m_col + 1'b1;
            else m_col = (m_col & ~CW'(len - 1)) | (CW'(m_col + 1'b1) & CW'(len - 1));
            m_idx++;
         end
      end
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 0, 1'b0, DW'(16'hDEAD + i), 1'b0, tag);
   endtask

   // monitor: compare each cycle's outputs away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (beat_vld !== e.vld || (e.vld && (beat_bank !== e.bank || beat_col !== e.col))
             || pre_req !== e.pre || (e.pre && pre_bank !== e.pbank)) begin
            errors++;
            $display("FAIL %s: got vld=%0b bank=%0d col=%0d pre=%0b pbank=%0d, exp vld=%0b bank=%0d col=%0d pre=%0b pbank=%0d",
                     e.tag, beat_vld, beat_bank, beat_col, pre_req, pre_bank,
                     e.vld, e.bank, e.col, e.pre, e.pbank);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got no completion, exp completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (beat_vld !== 1'b0 || pre_req !== 1'b0) begin
         errors++;
         $display("FAIL R9: got vld=%0b pre=%0b, exp 0 0", beat_vld, pre_req);
      end
      rst_n = 1'b1;
      idle(2, "R9");

      // R4: fill every bank with a full-page burst, each cut by the next command
      for (int b = 0; b < NB; b++) begin
         step(1'b1, b, 0, 1'b0, 0, 1'b1, pat(b, 0, 0), 1'b0, "R4");
         for (int c = 1; c < NCOL; c++) step(1'b0, 0, 0, 1'b0, 0, 1'b0, pat(b, c, 0), 1'b0, "R4");
      end
      // R6 and R5: masked single beat truncates the last full-page burst
      step(1'b1, 0, 5, 1'b0, 0, 1'b0, 16'hFFFF, 1'b1, "R6");
      idle(2, "R3");

      // R1/R2/R3: BL2, then trailing data ignored
      step(1'b1, 1, 10, 1'b0, 1, 1'b0, 16'h1111, 1'b0, "R1");
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 16'h2222, 1'b0, "R2");
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 16'h3333, 1'b0, "R3");
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 16'h4444, 1'b0, "R3");

      // R2: BL4 wrap from col 6 -> 6,7,4,5
      step(1'b1, 2, 6, 1'b0, 2, 1'b0, 16'hA006, 1'b0, "R2");
      for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 1'b0, 0, 1'b0, DW'(16'hA100 + i), 1'b0, "R2");

      // R2: BL8 from col 13 plus reserved code 5 treated as eight
      step(1'b1, 3, 13, 1'b0, 3, 1'b0, 16'hB00D, 1'b0, "R2");
      for (int i = 0; i < 8; i++) step(1'b0, 0, 0, 1'b0, 0, 1'b0, DW'(16'hB100 + i), 1'b0, "R2");
      step(1'b1, 0, 42, 1'b0, 5, 1'b0, 16'hC02A, 1'b0, "R2");
      for (int i = 0; i < 8; i++) step(1'b0, 0, 0, 1'b0, 0, 1'b0, DW'(16'hC100 + i), 1'b0, "R2");

      // R7: BL1 with auto-precharge
      step(1'b1, 2, 100, 1'b1, 0, 1'b0, 16'hD064, 1'b0, "R7");
      idle(2, "R7");

      // R5/R7: BL4 auto-precharge truncated after two beats, no request
      step(1'b1, 0, 20, 1'b1, 2, 1'b0, 16'hE014, 1'b0, "R5");
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 16'hE015, 1'b0, "R5");
      step(1'b1, 3, 50, 1'b0, 1, 1'b0, 16'hE032, 1'b0, "R5");
      idle(3, "R7");

      // R7: BL8 auto-precharge runs out fully
      step(1'b1, 1, 64, 1'b1, 3, 1'b0, 16'hF040, 1'b0, "R7");
      for (int i = 0; i < 9; i++) step(1'b0, 0, 0, 1'b0, 0, 1'b0, DW'(16'hF100 + i), 1'b0, "R7");

      // R8: back-to-back single beats, alternating and repeated banks
      for (int i = 0; i < 6; i++) step(1'b1, i % 3, 200 + i, 1'b0, 0, 1'b0, DW'(16'h8800 + i), 1'b0, "R8");
      step(1'b1, 1, 210, 1'b0, 0, 1'b0, 16'h8810, 1'b0, "R8");
      step(1'b1, 1, 211, 1'b0, 0, 1'b0, 16'h8811, 1'b0, "R8");
      idle(2, "R3");

      // R6: mask in the middle of a BL4 burst
      step(1'b1, 3, 120, 1'b0, 2, 1'b0, 16'h6078, 1'b0, "R6");
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 16'h6079, 1'b1, "R6");
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 16'h607A, 1'b0, "R6");
      step(1'b0, 0, 0, 1'b0, 0, 1'b0, 16'h607B, 1'b1, "R6");
      idle(2, "R3");

      // R4: full page from col 254 wraps to 0, then a new write ends it
      step(1'b1, 2, 254, 1'b1, 0, 1'b1, 16'h70FE, 1'b0, "R4");
      for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 1'b0, 0, 1'b0, DW'(16'h7100 + i), 1'b0, "R4");
      step(1'b1, 0, 30, 1'b0, 0, 1'b0, 16'h701E, 1'b0, "R5");
      idle(4, "R3");

      // drain the scoreboard
      @(negedge clk);
      @(negedge clk);

      // R1/R3/R6: sweep every stored word against the shadow
      for (int b = 0; b < NB; b++) begin
         for (int c = 0; c < NCOL; c++) begin
            peek_bank = BW'(b); peek_col = CW'(c);
            #1;
            checks++;
            if (peek_data !== shadow[b][c]) begin
               errors++;
               $display("FAIL R3/R6 bank %0d col %0d: got %h, exp %h", b, c, peek_data, shadow[b][c]);
            end
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule